// File: doc/BRIEF.md
# Holdoff-Aware Sample Readout Scheduler

This controller sits on the host side of a converter link. It decides the exact cycle on which a serial read of buffered samples may begin. The converter drives an active-low ready line while at least one sample sits in its output FIFO. If a read starts at the same moment the converter pushes the next sample into that FIFO, the ready line can freeze, and only a reset recovers it. The scheduler prevents this. It anchors a free-running phase counter on the first falling edge of ready. It then refuses to start a read inside a symmetric guard band around every whole multiple of the sample period, measured from that anchor.

The system hands over read requests through a valid/ready handshake. A request is taken when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low while an accepted request waits, which is the only back-pressure. A waiting request leaves as one single-cycle `start_o` pulse. That pulse comes on the first cycle in which the phase is outside the guard band, the read engine is idle and ready is low. A separate watchdog raises `lock_o` when ready has held one level for longer than a programmable number of sample periods. This is the symptom of the freeze described above, and a reset is then needed.

The sample period and the guard half-width are run-time inputs in clock cycles. A zero on either input selects a default of 2 ms or 1 us at the configured clock frequency. Reads that always finish within one period of ready falling keep the FIFO at no more than one sample. With a 2 ms period and a 1 us guard, each period leaves a start window of about 1.998 ms.

Top module: `readout_sched`

## Requirements
- R1: `start_o` is high only in a cycle where `rdy_n_i` is low (0 = a sample is waiting).
- R2: The first cycle in which `rdy_n_i` is low after having been high, counted after reset or re-arm, is the anchor cycle with phase 0. `anchored_o` is high from the next cycle on. Later falling edges do not move the anchor.
- R3: The phase of a cycle is its distance in cycles from the anchor, modulo the effective period P. Starts are blocked when phase <= G or phase >= P-G, where G is the effective guard. `in_guard_o` is high when anchored and the phase lies in that blocked set. This leaves P-2G-1 open cycles per period.
- R4: `start_o` = pending AND phase open AND `busy_i` low AND `rdy_n_i` low, evaluated in the same cycle. A request that waits through a guard band therefore issues on phase G+1.
- R5: `req_ready_o` is high exactly when no request is pending. A handshake sets pending. A `start_o` clears it, so each accepted request produces exactly one start.
- R6: No `start_o` is issued while `busy_i` is high. The request stays pending and issues in the first allowed cycle after `busy_i` falls.
- R7: Let c be the cycle in which `rdy_n_i` differs from its previous value (reset counts as a change to high). `lock_o` is high from cycle c+L*P+1 until the cycle after the next change, with L = `lock_periods_i` (L >= 1).
- R8: `period_cyc_i` = 0 selects P = CLK_HZ/500 (2 ms). `guard_cyc_i` = 0 selects G = CLK_HZ/1e6 (1 us, minimum 1).
- R9: A high `rearm_i` clears the anchor. No start is issued until a new falling edge of ready re-anchors the phase.
- R10: During reset, `start_o`, `anchored_o` and `lock_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rearm_i | input | 1 | Drop the phase anchor and wait for a new ready falling edge |
| rdy_n_i | input | 1 | Converter ready, low while the FIFO holds a sample |
| busy_i | input | 1 | Serial read engine is busy |
| req_valid_i | input | 1 | Read request offered |
| req_ready_o | output | 1 | Request can be accepted (none pending) |
| start_o | output | 1 | One-cycle read start pulse |
| period_cyc_i | input | PW | Sample period in cycles, 0 = default |
| guard_cyc_i | input | PW | Guard half-width in cycles, 0 = default |
| lock_periods_i | input | LW | Periods of unchanged ready that flag a lock |
| anchored_o | output | 1 | Phase counter is anchored |
| in_guard_o | output | 1 | Anchored and current phase is inside a guard band |
| lock_o | output | 1 | Suspected ready lock |

## Verification
The bench builds the block with CLK_HZ = 1 MHz. This shrinks the default period to 2000 cycles and the default guard to 1 cycle, so the zero-selects-default path, including the blocked phases 1999, 0 and 1 on either side of a boundary, can be reached within a short run. The explicit configurations use periods of 40 and 25 cycles with guards of 3 and 5. Over a few thousand random cycles, these short periods bring many boundary crossings, guard-band waits, busy stalls, re-arms and lock timeouts of one or two periods within reach.

// File: rtl/readout_sched_pkg.sv
package readout_sched_pkg;

  // Returns the configured value, or the fallback when the configured value is zero.
  function automatic logic [31:0] or_default(input logic [31:0] cfg, input logic [31:0] fallback);
    return (cfg == 32'd0) ? fallback : cfg;
  endfunction

endpackage

// File: rtl/readout_sched_phase.sv
module readout_sched_phase #(
  parameter int unsigned PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rearm_i,
  input  logic          rdy_n_i,
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] guard_i,
  output logic          anchored_o,
  output logic          open_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic          rdy_prev_q;
  logic          anch_q;
  logic [PW-1:0] ph_q;
  logic          fall;

  assign fall = rdy_prev_q & ~rdy_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_prev_q <= 1'b1;
      anch_q     <= 1'b0;
      ph_q       <= '0;
    end else begin
      rdy_prev_q <= rdy_n_i;
      if (rearm_i) begin
        anch_q <= 1'b0;
      end else if (!anch_q && fall) begin
        anch_q <= 1'b1;
        ph_q   <= (period_i > ONE) ? ONE : '0;
      end else if (anch_q) begin
        ph_q <= (ph_q == period_i - ONE) ? '0 : ph_q + ONE;
      end
    end
  end

  assign anchored_o = anch_q;
  assign open_o     = anch_q && (ph_q > guard_i) && (ph_q < (period_i - guard_i));

  a_r2_anchor_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (anch_q && !rearm_i) |=> anch_q);
  a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    anch_q |-> (ph_q < period_i));
  a_r3_phase_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (anch_q && !rearm_i && (ph_q != period_i - ONE)) |=> (ph_q == $past(ph_q) + ONE));
endmodule

// File: rtl/readout_sched_lockwd.sv
module readout_sched_lockwd #(
  parameter int unsigned PW = 24,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rdy_n_i,
  input  logic [PW-1:0] period_i,
  input  logic [LW-1:0] lock_periods_i,
  output logic          lock_o
);
  localparam logic [PW-1:0] ONE  = PW'(1);
  localparam logic [LW-1:0] LONE = LW'(1);

  logic          lvl_q;
  logic [PW-1:0] cyc_q;
  logic [LW-1:0] per_q;
  logic          change;

  assign change = rdy_n_i ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cyc_q <= '0;
      per_q <= '0;
    end else begin
      lvl_q <= rdy_n_i;
      if (change) begin
        cyc_q <= '0;
        per_q <= '0;
      end else if (cyc_q == period_i - ONE) begin
        cyc_q <= '0;
        if (per_q < lock_periods_i) per_q <= per_q + LONE;
      end else begin
        cyc_q <= cyc_q + ONE;
      end
    end
  end

  assign lock_o = (per_q >= lock_periods_i);

  a_r7_change_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (change && (lock_periods_i != '0)) |=> !lock_o);
  a_r7_lock_sticks_while_level: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !change) |=> lock_o);
endmodule

// File: rtl/readout_sched_issue.sv
module readout_sched_issue (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  output logic req_ready_o,
  input  logic open_i,
  input  logic busy_i,
  input  logic rdy_n_i,
  output logic start_o
);
  logic pend_q;

  assign req_ready_o = ~pend_q;
  assign start_o     = pend_q & open_i & ~busy_i & ~rdy_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (start_o) begin
      pend_q <= 1'b0;
    end else if (req_valid_i && !pend_q) begin
      pend_q <= 1'b1;
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  a_r5_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> req_ready_o);
  a_r5_wait_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready_o && !start_o) |=> !req_ready_o);
endmodule

// File: rtl/readout_sched.sv
module readout_sched #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned PW     = 24,
  parameter int unsigned LW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rearm_i,
  input  logic          rdy_n_i,
  input  logic          busy_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  output logic          start_o,
  input  logic [PW-1:0] period_cyc_i,
  input  logic [PW-1:0] guard_cyc_i,
  input  logic [LW-1:0] lock_periods_i,
  output logic          anchored_o,
  output logic          in_guard_o,
  output logic          lock_o
);
  localparam int unsigned DEF_PERIOD    = CLK_HZ / 500;
  localparam int unsigned DEF_GUARD_RAW = CLK_HZ / 1_000_000;
  localparam int unsigned DEF_GUARD     = (DEF_GUARD_RAW == 0) ? 1 : DEF_GUARD_RAW;

  logic [PW-1:0] eff_period;
  logic [PW-1:0] eff_guard;
  logic          open_w;
  logic          anch_w;

  assign eff_period = PW'(readout_sched_pkg::or_default(32'(period_cyc_i), 32'(DEF_PERIOD)));
  assign eff_guard  = PW'(readout_sched_pkg::or_default(32'(guard_cyc_i), 32'(DEF_GUARD)));

  readout_sched_phase #(.PW(PW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .rearm_i   (rearm_i),
    .rdy_n_i   (rdy_n_i),
    .period_i  (eff_period),
    .guard_i   (eff_guard),
    .anchored_o(anch_w),
    .open_o    (open_w)
  );

  readout_sched_lockwd #(.PW(PW), .LW(LW)) u_lockwd (
    .clk           (clk),
    .rst_n         (rst_n),
    .rdy_n_i       (rdy_n_i),
    .period_i      (eff_period),
    .lock_periods_i(lock_periods_i),
    .lock_o        (lock_o)
  );

  readout_sched_issue u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .open_i     (open_w),
    .busy_i     (busy_i),
    .rdy_n_i    (rdy_n_i),
    .start_o    (start_o)
  );

  assign anchored_o = anch_w;
  assign in_guard_o = anch_w & ~open_w;

  a_r3_no_start_in_guard: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (anchored_o && !in_guard_o));
  a_r1_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !rdy_n_i);
  a_r6_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !start_o);
  a_r9_rearm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> !start_o);
endmodule

// File: tb/tb_readout_sched.sv
module tb_readout_sched;
  localparam int unsigned CLK_HZ = 1_000_000;
  localparam int unsigned PW = 16;
  localparam int unsigned LW = 4;
  localparam int DEFP = 2000;
  localparam int DEFG = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rearm = 1'b0, rdy_n = 1'b1, busy = 1'b0, req_valid = 1'b0;
  logic req_ready_o, start_o, anchored_o, in_guard_o, lock_o;
  logic [PW-1:0] period = '0, guard = '0;
  logic [LW-1:0] lockp = '0;

  int checks = 0, errors = 0;
  int mp, mg, ml, m_ph, m_cyc, m_per;
  bit m_prev, m_wprev, m_anch, m_pend;
  int cnum = 0, s_cyc = 0;
  bit s_start, s_lock, s_guard;

  always #5 clk = ~clk;

  readout_sched #(.CLK_HZ(CLK_HZ), .PW(PW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .rearm_i(rearm), .rdy_n_i(rdy_n), .busy_i(busy),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .start_o(start_o),
    .period_cyc_i(period), .guard_cyc_i(guard), .lock_periods_i(lockp),
    .anchored_o(anchored_o), .in_guard_o(in_guard_o), .lock_o(lock_o));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cnum);
    end
  endtask

  function automatic bit phase_open(input int ph);
    return (ph > mg) && (ph < mp - mg);
  endfunction

  function automatic int next_open(input int c, input int anchor);
    int x = c;
    while (!phase_open((x - anchor) % mp)) x++;
    return x;
  endfunction

  task automatic cyc();
    bit e_open, e_start, fall;
    #2;
    e_open  = m_anch && phase_open(m_ph);
    e_start = m_pend && e_open && !busy && !rdy_n;
    chk("R4 R6 start", start_o, e_start);
    chk("R5 req_ready", req_ready_o, !m_pend);
    chk("R2 R9 anchored", anchored_o, m_anch);
    chk("R3 in_guard", in_guard_o, m_anch && !e_open);
    chk("R7 lock", lock_o, m_per >= ml);
    if (start_o) chk("R1 start with ready high", rdy_n, 0);
    s_start = start_o; s_lock = lock_o; s_guard = in_guard_o; s_cyc = cnum;
    @(posedge clk);
    fall = m_prev && !rdy_n;
    if (rearm) m_anch = 0;
    else if (!m_anch && fall) begin m_anch = 1; m_ph = (mp > 1) ? 1 : 0; end
    else if (m_anch) m_ph = (m_ph == mp - 1) ? 0 : m_ph + 1;
    if (e_start) m_pend = 0;
    else if (req_valid && !m_pend) m_pend = 1;
    if (rdy_n != m_wprev) begin m_cyc = 0; m_per = 0; end
    else if (m_cyc == mp - 1) begin m_cyc = 0; if (m_per < ml) m_per++; end
    else m_cyc++;
    m_prev = rdy_n; m_wprev = rdy_n;
    cnum++;
    @(negedge clk);
  endtask

  task automatic do_reset(input int p, input int g, input int l);
    rst_n = 1'b0; period = PW'(p); guard = PW'(g); lockp = LW'(l);
    rdy_n = 1'b1; req_valid = 1'b0; busy = 1'b0; rearm = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R10 start", start_o, 0);
    chk("R10 req_ready", req_ready_o, 1);
    chk("R10 anchored", anchored_o, 0);
    chk("R10 lock", lock_o, 0);
    mp = (p == 0) ? DEFP : p; mg = (g == 0) ? DEFG : g; ml = l;
    m_ph = 0; m_cyc = 0; m_per = 0; m_prev = 1; m_wprev = 1; m_anch = 0; m_pend = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom % 12 == 0) rdy_n = ~rdy_n;
      req_valid = ($urandom % 4 == 0);
      busy = ($urandom % 3 == 0);
      rearm = ($urandom % 400 == 0);
      cyc();
    end
    req_valid = 0; busy = 0; rearm = 0;
  endtask

  task automatic first_start(input int limit, output int got, output int count);
    got = -1; count = 0;
    for (int i = 0; i < limit; i++) begin
      cyc();
      if (s_start) begin count++; if (got < 0) got = s_cyc; end
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a, got, n, t0, ex;
    void'($urandom(32'd20240611));
    // Directed: P=40, G=3, L=2
    do_reset(40, 3, 2);
    req_valid = 1; cyc(); req_valid = 0;
    repeat (4) cyc();
    rdy_n = 0; a = cnum;
    first_start(12, got, n);
    chk("R4 pending issues at phase G+1", got, a + 4);
    // request, ready bounces high then low: anchor must not move; busy stalls
    busy = 1; req_valid = 1; cyc(); req_valid = 0;
    rdy_n = 1; repeat (3) cyc(); rdy_n = 0;
    n = 0;
    while ((cnum - a) % mp != 36) begin cyc(); if (s_start) n++; end
    chk("R6 no start while busy", n, 0);
    busy = 0; ex = cnum;
    first_start(5, got, n);
    chk("R6 R2 start once busy drops", got, ex);
    // request arriving in the guard band waits for phase G+1
    while ((cnum - a) % mp != 37) cyc();
    req_valid = 1; ex = next_open(cnum, a); cyc(); req_valid = 0;
    first_start(12, got, n);
    chk("R3 guard wait", got, ex);
    // lock watchdog
    rdy_n = 1; t0 = cnum; got = -1;
    for (int i = 0; i < 120; i++) begin cyc(); if (s_lock && got < 0) got = s_cyc - t0; end
    chk("R7 lock delay", got, 2 * 40 + 1);
    rdy_n = 0; cyc(); cyc();
    chk("R7 lock clears", s_lock, 0);
    // rearm
    rearm = 1; cyc(); rearm = 0;
    req_valid = 1; cyc(); req_valid = 0;
    first_start(60, got, n);
    chk("R9 no start before re-anchor", n, 0);
    rdy_n = 1; cyc(); rdy_n = 0; a = cnum;
    first_start(80, got, n);
    chk("R9 re-anchored start", got, a + 4);
    chk("R5 one start per request", n, 1);
    rand_run(3000);
    do_reset(25, 5, 1);
    rand_run(3000);
    // defaults
    do_reset(0, 0, 3);
    req_valid = 1; cyc(); req_valid = 0;
    rdy_n = 0; a = cnum;
    first_start(6, got, n);
    chk("R8 default guard start", got, a + 2);
    while (cnum < a + 1998) cyc();
    cyc(); chk("R8 phase 1998 open", s_guard, 0);
    cyc(); chk("R8 phase 1999 guard", s_guard, 1);
    cyc(); chk("R8 phase 0 guard", s_guard, 1);
    cyc(); chk("R8 phase 1 guard", s_guard, 1);
    cyc(); chk("R8 phase 2 open", s_guard, 0);
    rand_run(4000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule